// File: doc/BRIEF.md
# Streaming particle memory sequencer

This block sits between the processing stages of a particle filter and a generic burst memory port. A stage never supplies an address. It pulses `start_i` together with a region select. The sequencer then streams every particle record of that region in index order, from record 0 up to record N-1. Each record occupies one burst of four 128-bit beats. Read requests go to memory ahead of demand, and the returned beats wait in a local FIFO, so the consumer does not see memory latency.

A write stream can run in the same stage. Each write beat is placed at the next sequential address of the selected region. The read side and the write side each raise their own done flag after 4·N beats. After that, the side ignores requests until the next start pulse.

There are three regions. The main region holds quaternion-form particles. Two further regions hold Euler-angle-form copies used by a correction pass. The base address of each region is a parameter. The memory may return read data with any latency. It returns the beats of each burst in request order.

Top module: `particle_stream_seq`

## Requirements
- R1: After a start, read requests carry the addresses base+4k for k = 0, 1, … in increasing order. Delivered beat j (j = 0 … 4N-1) is the memory word at address base+j.
- R2: A start pulse sets both address counters to zero and clears both done flags. During the start cycle `rd_valid_o`, `wr_ready_o` and `mem_rd_req_o` are low. Before the first start pulse no request is issued and no beat is delivered or accepted.
- R3: Read requests are issued without consumer demand while outstanding beats, beats still to be discarded, FIFO occupancy and one more burst together fit in FIFO_DEPTH. With the consumer stalled, exactly FIFO_DEPTH/4 requests are issued. The FIFO never overflows.
- R4: `region_i` is sampled at the start pulse. Value 0 selects the main base, 1 the first Euler base, 2 the second Euler base, and 3 falls back to the main base.
- R5: Each read request returns 4 beats of 128 bits. `rd_last_o` is high exactly on delivered beats with j mod 4 = 3.
- R6: `rd_done_o` rises after beat 4N-1 is delivered. `wr_done_o` rises after beat 4N-1 is accepted. From then until the next start there is no read request, no delivered beat, and `wr_ready_o` and `mem_wr_valid_o` stay low.
- R7: Write beat j goes to memory address base+j with its data unchanged. `mem_wr_valid_o` follows `wr_valid_i` and `wr_ready_o` follows `mem_wr_ready_i` while the write stream is open.
- R8: A start pulse in the middle of a read stream discards the FIFO contents and any data still in flight. The first beat delivered afterwards is beat 0 of the newly selected region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Stage start pulse |
| region_i | input | 2 | Region select, sampled at start |
| rd_valid_o | output | 1 | Read beat available |
| rd_ready_i | input | 1 | Consumer accepts read beat |
| rd_data_o | output | DATA_W | Read beat data |
| rd_last_o | output | 1 | Last beat of a record |
| rd_done_o | output | 1 | All read beats delivered |
| wr_valid_i | input | 1 | Producer write beat valid |
| wr_ready_o | output | 1 | Write beat accepted |
| wr_data_i | input | DATA_W | Write beat data |
| wr_done_o | output | 1 | All write beats accepted |
| mem_rd_req_o | output | 1 | Burst read request |
| mem_rd_gnt_i | input | 1 | Memory accepts read request |
| mem_rd_addr_o | output | ADDR_W | Burst start address in beats |
| mem_rd_valid_i | input | 1 | Returned read beat valid |
| mem_rd_data_i | input | DATA_W | Returned read beat data |
| mem_wr_valid_o | output | 1 | Write beat to memory valid |
| mem_wr_ready_i | input | 1 | Memory accepts write beat |
| mem_wr_addr_o | output | ADDR_W | Write beat address |
| mem_wr_data_o | output | DATA_W | Write beat data |

## Verification
The assertions check the following on every cycle:
- The FIFO never overflows or underflows, and outstanding plus buffered beats never exceed the depth.
- Read and write addresses step by exactly one burst or one beat per handshake.
- A done side stays silent.
- A start clears both flags.

Only the bench scenarios can show:
- The data order and values across all four region codes.
- The exact prefetch count with a stalled consumer.
- The last-beat marking.
- That no stale beat survives a restart in the middle of a stream while the memory latency varies at random.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef enum logic [1:0] {
    RGN_MAIN  = 2'd0,
    RGN_EUL_A = 2'd1,
    RGN_EUL_B = 2'd2,
    RGN_SPARE = 2'd3
  } region_e;
endpackage

// File: rtl/pss_fifo.sv
module pss_fifo #(
  parameter int W     = 128,
  parameter int DEPTH = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       flush_i,
  input  logic                       push_i,
  input  logic [W-1:0]               data_i,
  input  logic                       pop_i,
  output logic [W-1:0]               data_o,
  output logic                       empty_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_i)  rd_ptr_q <= rd_ptr_q + 1'b1;
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem_q[wr_ptr_q] <= data_i;
  end

  assign data_o  = mem_q[rd_ptr_q];
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !flush_i && !pop_i) |-> (cnt_q < CW'(DEPTH)));
  p_no_underflow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/pss_rd_ctrl.sv
module pss_rd_ctrl #(
  parameter int N_REC  = 1024,
  parameter int BEATS  = 4,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              active_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              mem_rd_req_o,
  input  logic              mem_rd_gnt_i,
  output logic [ADDR_W-1:0] mem_rd_addr_o,
  input  logic              mem_rd_valid_i,
  input  logic [DATA_W-1:0] mem_rd_data_i,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_last_o,
  output logic              rd_done_o
);
  localparam int TOT  = N_REC * BEATS;
  localparam int RC_W = $clog2(N_REC+1);
  localparam int DC_W = $clog2(TOT+1);
  localparam int FC_W = $clog2(DEPTH+1);
  localparam int OC_W = $clog2(DEPTH+1) + 2;
  localparam int BC_W = $clog2(BEATS);

  logic [RC_W-1:0] req_q;
  logic [DC_W-1:0] dlv_q;
  logic [OC_W-1:0] outst_q, drop_q, used;
  logic [FC_W-1:0] fifo_cnt;
  logic            done_q, empty, issue, req_hs, push, pop, drop_dec, outst_dec;

  // credit covers beats in flight, beats to discard and beats buffered
  assign used      = drop_q + outst_q + OC_W'(fifo_cnt);
  assign issue     = active_i && !start_i && (req_q < RC_W'(N_REC))
                     && (used + OC_W'(BEATS) <= OC_W'(DEPTH));
  assign req_hs    = issue && mem_rd_gnt_i;
  assign drop_dec  = mem_rd_valid_i && (drop_q != '0);
  assign outst_dec = mem_rd_valid_i && (drop_q == '0);
  assign push      = outst_dec && !start_i;
  assign pop       = rd_valid_o && rd_ready_i;

  assign mem_rd_req_o  = issue;
  assign mem_rd_addr_o = base_i + ADDR_W'(req_q) * ADDR_W'(BEATS);
  assign rd_valid_o    = !empty && !start_i;
  assign rd_last_o     = (dlv_q[BC_W-1:0] == BC_W'(BEATS-1));
  assign rd_done_o     = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= '0;
      dlv_q   <= '0;
      outst_q <= '0;
      drop_q  <= '0;
      done_q  <= 1'b0;
    end else if (start_i) begin
      req_q   <= '0;
      dlv_q   <= '0;
      outst_q <= '0;
      drop_q  <= drop_q - OC_W'(drop_dec) + outst_q - OC_W'(outst_dec);
      done_q  <= 1'b0;
    end else begin
      if (req_hs) req_q <= req_q + 1'b1;
      outst_q <= outst_q + (req_hs ? OC_W'(BEATS) : '0) - OC_W'(outst_dec);
      drop_q  <= drop_q - OC_W'(drop_dec);
      if (pop) begin
        dlv_q <= dlv_q + 1'b1;
        if (dlv_q == DC_W'(TOT-1)) done_q <= 1'b1;
      end
    end
  end

  pss_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (start_i),
    .push_i  (push),
    .data_i  (mem_rd_data_i),
    .pop_i   (pop),
    .data_o  (rd_data_o),
    .empty_o (empty),
    .count_o (fifo_cnt)
  );

  p_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (outst_q + OC_W'(fifo_cnt)) <= OC_W'(DEPTH));
  p_rd_addr_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_req_o && mem_rd_gnt_i) |=>
      (mem_rd_addr_o == $past(mem_rd_addr_o) + ADDR_W'(BEATS)));
  p_rd_done_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_o |-> (!mem_rd_req_o && !rd_valid_o));
  p_rd_start_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !rd_done_o);
endmodule

// File: rtl/pss_wr_ctrl.sv
module pss_wr_ctrl #(
  parameter int N_REC  = 1024,
  parameter int BEATS  = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              active_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_done_o,
  output logic              mem_wr_valid_o,
  input  logic              mem_wr_ready_i,
  output logic [ADDR_W-1:0] mem_wr_addr_o,
  output logic [DATA_W-1:0] mem_wr_data_o
);
  localparam int TOT  = N_REC * BEATS;
  localparam int WC_W = $clog2(TOT+1);

  logic [WC_W-1:0] cnt_q;
  logic            done_q, open, hs;

  assign open           = active_i && !start_i && !done_q;
  assign wr_ready_o     = open && mem_wr_ready_i;
  assign mem_wr_valid_o = open && wr_valid_i;
  assign mem_wr_addr_o  = base_i + ADDR_W'(cnt_q);
  assign mem_wr_data_o  = wr_data_i;
  assign wr_done_o      = done_q;
  assign hs             = wr_valid_i && wr_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (hs) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == WC_W'(TOT-1)) done_q <= 1'b1;
    end
  end

  p_wr_addr_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_valid_o && mem_wr_ready_i) |=>
      (mem_wr_addr_o == $past(mem_wr_addr_o) + 1'b1));
  p_wr_done_block_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done_o |-> (!wr_ready_o && !mem_wr_valid_o));
  p_wr_start_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !wr_done_o);
endmodule

// File: rtl/particle_stream_seq.sv
module particle_stream_seq
  import pss_pkg::*;
#(
  parameter int          N_REC      = 1024,
  parameter int          BEATS      = 4,
  parameter int          DATA_W     = 128,
  parameter int          ADDR_W     = 32,
  parameter int          FIFO_DEPTH = 16,
  parameter logic [31:0] BASE_MAIN  = 32'h0000_0000,
  parameter logic [31:0] BASE_EUL_A = 32'h0010_0000,
  parameter logic [31:0] BASE_EUL_B = 32'h0020_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        region_i,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_last_o,
  output logic              rd_done_o,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_done_o,
  output logic              mem_rd_req_o,
  input  logic              mem_rd_gnt_i,
  output logic [ADDR_W-1:0] mem_rd_addr_o,
  input  logic              mem_rd_valid_i,
  input  logic [DATA_W-1:0] mem_rd_data_i,
  output logic              mem_wr_valid_o,
  input  logic              mem_wr_ready_i,
  output logic [ADDR_W-1:0] mem_wr_addr_o,
  output logic [DATA_W-1:0] mem_wr_data_o
);
  region_e           region_q;
  logic              active_q;
  logic [ADDR_W-1:0] base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      region_q <= RGN_MAIN;
      active_q <= 1'b0;
    end else if (start_i) begin
      region_q <= region_e'(region_i);
      active_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (region_q)
      RGN_EUL_A: base = ADDR_W'(BASE_EUL_A);
      RGN_EUL_B: base = ADDR_W'(BASE_EUL_B);
      default:   base = ADDR_W'(BASE_MAIN);
    endcase
  end

  pss_rd_ctrl #(
    .N_REC(N_REC), .BEATS(BEATS), .DEPTH(FIFO_DEPTH),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_rd (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .active_i       (active_q),
    .base_i         (base),
    .mem_rd_req_o   (mem_rd_req_o),
    .mem_rd_gnt_i   (mem_rd_gnt_i),
    .mem_rd_addr_o  (mem_rd_addr_o),
    .mem_rd_valid_i (mem_rd_valid_i),
    .mem_rd_data_i  (mem_rd_data_i),
    .rd_valid_o     (rd_valid_o),
    .rd_ready_i     (rd_ready_i),
    .rd_data_o      (rd_data_o),
    .rd_last_o      (rd_last_o),
    .rd_done_o      (rd_done_o)
  );

  pss_wr_ctrl #(
    .N_REC(N_REC), .BEATS(BEATS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_wr (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .active_i       (active_q),
    .base_i         (base),
    .wr_valid_i     (wr_valid_i),
    .wr_ready_o     (wr_ready_o),
    .wr_data_i      (wr_data_i),
    .wr_done_o      (wr_done_o),
    .mem_wr_valid_o (mem_wr_valid_o),
    .mem_wr_ready_i (mem_wr_ready_i),
    .mem_wr_addr_o  (mem_wr_addr_o),
    .mem_wr_data_o  (mem_wr_data_o)
  );

  p_idle_before_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> (!mem_rd_req_o && !rd_valid_o && !wr_ready_o && !mem_wr_valid_o));
endmodule

// File: tb/particle_stream_seq_bench.sv
`timescale 1ns/100ps
module particle_stream_seq_bench;
  localparam int N   = 6;
  localparam int D   = 8;
  localparam int B   = 4;
  localparam int TOT = N * B;
  localparam logic [31:0] BM = 32'h0000_0000;
  localparam logic [31:0] BA = 32'h0010_0000;
  localparam logic [31:0] BB = 32'h0020_0000;

  logic         clk_i = 1'b0, rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [1:0]   region_i = '0;
  logic         rd_valid_o, rd_ready_i = 1'b0, rd_last_o, rd_done_o;
  logic [127:0] rd_data_o;
  logic         wr_valid_i = 1'b0, wr_ready_o, wr_done_o;
  logic [127:0] wr_data_i = '0;
  logic         mem_rd_req_o, mem_rd_gnt_i = 1'b0, mem_rd_valid_i = 1'b0;
  logic [31:0]  mem_rd_addr_o, mem_wr_addr_o;
  logic [127:0] mem_rd_data_i = '0, mem_wr_data_o;
  logic         mem_wr_valid_o, mem_wr_ready_i = 1'b0;

  int vectors = 0, miscompares = 0;
  int dlv = 0, wr_acc = 0, req_seen = 0, cyc = 0;
  logic [31:0] exp_base = BM;
  bit hold_rd = 1'b0, prod_en = 1'b0;
  int unsigned q_addr[$], q_due[$];
  int unsigned cur = 0, beat_rem = 0;

  always #2 clk_i = ~clk_i;

  particle_stream_seq #(
    .N_REC(N), .BEATS(B), .DATA_W(128), .ADDR_W(32), .FIFO_DEPTH(D),
    .BASE_MAIN(BM), .BASE_EUL_A(BA), .BASE_EUL_B(BB)
  ) u_particle_stream_seq (.*);

  function automatic logic [127:0] mem_word(logic [31:0] a);
    return {a, a ^ 32'h5a5a_c3c3, ~a, a + 32'h1357_9bdf};
  endfunction

  function automatic logic [127:0] wr_word(int j);
    logic [31:0] v = 32'hfeed_0000 + 32'(j);
    return {v, ~v, v ^ 32'h0f0f_1234, 32'(j) * 32'd7};
  endfunction

  function automatic logic [31:0] base_of(logic [1:0] r);
    case (r)
      2'd1:    return BA;
      2'd2:    return BB;
      default: return BM;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // memory model, producer and consumer
  initial begin
    void'($urandom(32'd2024));
    forever begin
      @(negedge clk_i); #0.5;
      if (start_i) begin
        dlv = 0; wr_acc = 0; req_seen = 0; exp_base = base_of(region_i);
      end
      mem_rd_valid_i = 1'b0;
      if (beat_rem == 0 && q_addr.size() > 0 && q_due[0] <= cyc) begin
        cur = q_addr.pop_front();
        void'(q_due.pop_front());
        beat_rem = B;
      end
      if (beat_rem > 0 && ($urandom % 4) != 0) begin
        mem_rd_valid_i = 1'b1;
        mem_rd_data_i  = mem_word(cur);
        cur++;
        beat_rem--;
      end
      mem_rd_gnt_i   = ($urandom % 3) != 0;
      rd_ready_i     = hold_rd ? 1'b0 : (($urandom % 3) != 0);
      wr_valid_i     = prod_en && (($urandom % 4) != 0);
      wr_data_i      = wr_word(wr_acc);
      mem_wr_ready_i = ($urandom % 3) != 0;
      #0.5;
      if (start_i)
        chk(!rd_valid_o && !mem_rd_req_o && !wr_ready_o, "R2 start cycle quiet",
            {rd_valid_o, mem_rd_req_o, wr_ready_o}, '0);
      if (mem_rd_req_o && mem_rd_gnt_i) begin
        chk(mem_rd_addr_o == exp_base + 32'(req_seen * B), "R1 request address",
            mem_rd_addr_o, exp_base + 32'(req_seen * B));
        q_addr.push_back(mem_rd_addr_o);
        q_due.push_back(cyc + 2 + ($urandom % 5));
        req_seen++;
      end
      if (rd_valid_o && rd_ready_i) begin
        chk(dlv < TOT, "R6 beat after last", dlv, TOT - 1);
        chk(rd_data_o == mem_word(exp_base + 32'(dlv)), "R1 R4 read data",
            rd_data_o, mem_word(exp_base + 32'(dlv)));
        chk(rd_last_o == ((dlv % B) == B - 1), "R5 last flag",
            rd_last_o, ((dlv % B) == B - 1));
        dlv++;
      end
      if (mem_wr_valid_o && mem_wr_ready_i) begin
        chk(wr_valid_i && wr_ready_o, "R7 handshake pass", {wr_valid_i, wr_ready_o}, 2'b11);
        chk(mem_wr_addr_o == exp_base + 32'(wr_acc), "R7 write address",
            mem_wr_addr_o, exp_base + 32'(wr_acc));
        chk(mem_wr_data_o == wr_word(wr_acc), "R7 write data",
            mem_wr_data_o, wr_word(wr_acc));
        wr_acc++;
      end
      cyc++;
    end
  end

  task automatic do_start(logic [1:0] r);
    @(negedge clk_i);
    region_i = r;
    start_i  = 1'b1;
    @(negedge clk_i);
    start_i  = 1'b0;
  endtask

  task automatic wait_stage();
    int n = 0;
    do begin
      @(negedge clk_i); #1.5; n++;
    end while ((dlv < TOT || wr_acc < TOT) && n < 5000);
    chk(dlv == TOT, "R6 read beats", dlv, TOT);
    chk(wr_acc == TOT, "R6 write beats", wr_acc, TOT);
    @(negedge clk_i); #1.5;
    chk(rd_done_o, "R6 read done", rd_done_o, 1);
    chk(wr_done_o, "R6 write done", wr_done_o, 1);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk_i); #1.5;
      chk(!rd_valid_o && !mem_rd_req_o && !wr_ready_o && !mem_wr_valid_o, "R6 quiet after done",
          {rd_valid_o, mem_rd_req_o, wr_ready_o, mem_wr_valid_o}, '0);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    chk(1'b0, "watchdog expired", cyc, 0);
    summary();
  end

  initial begin
    prod_en = 1'b1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R2: idle before first start, even with traffic offered
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i); #1.5;
      chk(!mem_rd_req_o && !rd_valid_o && !wr_ready_o && !mem_wr_valid_o
          && !rd_done_o && !wr_done_o, "R2 reset idle",
          {mem_rd_req_o, rd_valid_o, wr_ready_o, mem_wr_valid_o, rd_done_o, wr_done_o}, '0);
    end
    // R3: prefetch with stalled consumer
    hold_rd = 1'b1;
    do_start(2'd0);
    repeat (40) @(negedge clk_i);
    #1.5;
    chk(req_seen == D / B, "R3 prefetch depth", req_seen, D / B);
    chk(rd_valid_o, "R3 data buffered", rd_valid_o, 1);
    chk(!rd_done_o, "R2 done cleared", rd_done_o, 0);
    hold_rd = 1'b0;
    wait_stage();
    // R4: every region code
    for (int r = 1; r < 4; r++) begin
      do_start(2'(r));
      wait_stage();
    end
    // R8: restart mid-stream into another region
    do_start(2'd1);
    while (dlv < 5) begin @(negedge clk_i); #1.5; end
    do_start(2'd2);
    #1.5;
    chk(!rd_done_o && !wr_done_o, "R8 restart clears", {rd_done_o, wr_done_o}, '0);
    wait_stage();
    // R2: restart after done reopens the main region
    do_start(2'd0);
    wait_stage();
    summary();
  end
endmodule